// File: doc/BRIEF.md
# Segmented Physical Address Generator

This block keeps four 16-bit segment registers and turns a selected segment and an offset into a physical memory address. It shifts the selected register left by four bit positions to form a base. It then adds the effective address, zero-extended to the base width. A mode input chooses what happens to the carry out of bit 19. In compatibility mode the carry is dropped, so the address wraps inside 1 MB. In extended mode the carry is kept as bit 20, which gives a 21-bit address.

The effective address can be presented as a 16-bit value or as a 32-bit value. A 32-bit value above 65535 does not produce an address. The block raises a fault flag instead and drives both address outputs to zero. The fault is only reported; handling it is left to the surrounding logic.

Segment registers are loaded through three write paths. The ordinary write port can load the extra, stack and data registers. It cannot change the code register. The code register has its own load port for far transfers. A pointer-load port updates the data register.

Top module: `seg_addr_gen`

## Requirements
- R1: The address is (segment << 4) + zero-extended low 16 bits of the effective address.
- R2: With ext_mode=0 the carry out of bit 19 is discarded: lin_addr[20]=0 and lin_addr[19:0] is the sum modulo 2^20.
- R3: With ext_mode=1, lin_addr carries the full 21-bit sum. In both modes wrap_addr is the sum modulo 2^20.
- R4: With ea_wide=1 and ea > 65535, fault=1 and both address outputs are zero. With ea_wide=1 and ea <= 65535 there is no fault. With ea_wide=0, ea[31:16] is ignored and no fault is raised.
- R5: seg_sel encoding: 2'b00 extra, 2'b01 code, 2'b10 stack, 2'b11 data.
- R6: wr_en loads wr_data into the register named by wr_sel (same encoding as R5) at the next rising edge. When wr_sel=2'b01 (code), the write is ignored.
- R7: far_ld loads far_cs into the code register at the next rising edge.
- R8: ptr_ld loads ptr_data into the data register at the next rising edge. When ptr_ld and a wr_en to data occur in the same cycle, ptr_ld wins. A wr_en to another register in that cycle still takes effect.
- R9: Reset sets the code register to 16'hFFFF and the other three registers to zero.
- R10: The address and fault outputs are combinational in seg_sel, ea, ea_wide and ext_mode. No clock edge is needed for them to follow these inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| seg_sel | input | 2 | Segment used for the address (R5 encoding) |
| ea | input | 32 | Effective address |
| ea_wide | input | 1 | 1: ea is a 32-bit value and is range checked |
| ext_mode | input | 1 | 1: keep the carry as bit 20 |
| wr_en | input | 1 | Ordinary segment write |
| wr_sel | input | 2 | Target of the ordinary write |
| wr_data | input | 16 | Ordinary write data |
| far_ld | input | 1 | Far-transfer load of the code register |
| far_cs | input | 16 | New code register value |
| ptr_ld | input | 1 | Pointer-load of the data register |
| ptr_data | input | 16 | New data register value |
| lin_addr | output | 21 | Linear address |
| wrap_addr | output | 20 | 20-bit wrapped address |
| fault | output | 1 | Effective address out of range |

## Verification
A wrong segment register value shows up as a wrong address as soon as that segment is selected, one cycle after the faulty write. This includes a code register changed through the ordinary port. A wrong carry or range decision is visible in the same cycle the inputs are applied. The bench therefore reads every register back through the address outputs with a zero offset. It also sweeps segment and offset values across the 1 MB boundary in both modes.

// File: rtl/seg_addr_pkg.sv
package seg_addr_pkg;
  typedef enum logic [1:0] {
    SEG_EXTRA = 2'b00,
    SEG_CODE  = 2'b01,
    SEG_STACK = 2'b10,
    SEG_DATA  = 2'b11
  } seg_id_e;

  localparam int unsigned NUM_SEG = 4;
endpackage

// File: rtl/seg_regfile.sv
module seg_regfile
  import seg_addr_pkg::*;
#(
  parameter int unsigned SEG_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [SEG_W-1:0] wr_data,
  input  logic             far_ld,
  input  logic [SEG_W-1:0] far_cs,
  input  logic             ptr_ld,
  input  logic [SEG_W-1:0] ptr_data,
  input  logic [1:0]       rd_sel,
  output logic [SEG_W-1:0] rd_seg,
  output logic [SEG_W-1:0] code_seg
);
  logic [SEG_W-1:0] seg_q [NUM_SEG];
  logic [SEG_W-1:0] seg_d [NUM_SEG];
  logic             seg_en [NUM_SEG];

  for (genvar i = 0; i < NUM_SEG; i++) begin : g_seg
    localparam logic [1:0]       IDX   = i[1:0];
    localparam logic [SEG_W-1:0] RST_V = (IDX == SEG_CODE) ? '1 : '0;

    // next-state selection for this register
    always_comb begin
      seg_en[i] = 1'b0;
      seg_d[i]  = seg_q[i];
      if (IDX == SEG_CODE) begin
        if (far_ld) begin
          seg_en[i] = 1'b1;
          seg_d[i]  = far_cs;
        end
      end else if (IDX == SEG_DATA && ptr_ld) begin
        seg_en[i] = 1'b1;
        seg_d[i]  = ptr_data;
      end else if (wr_en && wr_sel == IDX) begin
        seg_en[i] = 1'b1;
        seg_d[i]  = wr_data;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        seg_q[i] <= RST_V;
      end else if (seg_en[i]) begin
        seg_q[i] <= seg_d[i];
      end
    end
  end

  assign rd_seg   = seg_q[rd_sel];
  assign code_seg = seg_q[SEG_CODE];
endmodule

// File: rtl/seg_ea_check.sv
module seg_ea_check #(
  parameter int unsigned EA_W  = 32,
  parameter int unsigned OFS_W = 16
) (
  input  logic [EA_W-1:0]  ea,
  input  logic             ea_wide,
  output logic [OFS_W-1:0] ofs,
  output logic             fault
);
  localparam int unsigned HI_W = EA_W - OFS_W;

  logic [HI_W-1:0] ea_hi;

  assign ea_hi = ea[EA_W-1:OFS_W];
  assign ofs   = ea[OFS_W-1:0];
  assign fault = ea_wide & (|ea_hi);
endmodule

// File: rtl/seg_addr_calc.sv
module seg_addr_calc #(
  parameter int unsigned SEG_W = 16,
  parameter int unsigned OFS_W = 16,
  parameter int unsigned SHIFT = 4
) (
  input  logic [SEG_W-1:0]       seg,
  input  logic [OFS_W-1:0]       ofs,
  input  logic                   ext_mode,
  input  logic                   fault,
  output logic [SEG_W+SHIFT:0]   lin_addr,
  output logic [SEG_W+SHIFT-1:0] wrap_addr
);
  localparam int unsigned ADDR_W = SEG_W + SHIFT + 1;

  logic [ADDR_W-1:0] base;
  logic [ADDR_W-1:0] ofs_x;
  logic [ADDR_W-1:0] sum;

  assign base  = {1'b0, seg, {SHIFT{1'b0}}};
  assign ofs_x = {{(ADDR_W-OFS_W){1'b0}}, ofs};
  assign sum   = base + ofs_x;

  always_comb begin
    if (fault) begin
      lin_addr  = '0;
      wrap_addr = '0;
    end else begin
      wrap_addr = sum[ADDR_W-2:0];
      lin_addr  = {sum[ADDR_W-1] & ext_mode, sum[ADDR_W-2:0]};
    end
  end
endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen #(
  parameter int unsigned SEG_W  = 16,
  parameter int unsigned EA_W   = 32,
  parameter int unsigned OFS_W  = 16,
  parameter int unsigned SHIFT  = 4,
  localparam int unsigned ADDR_W = SEG_W + SHIFT + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        seg_sel,
  input  logic [EA_W-1:0]   ea,
  input  logic              ea_wide,
  input  logic              ext_mode,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [SEG_W-1:0]  wr_data,
  input  logic              far_ld,
  input  logic [SEG_W-1:0]  far_cs,
  input  logic              ptr_ld,
  input  logic [SEG_W-1:0]  ptr_data,
  output logic [ADDR_W-1:0] lin_addr,
  output logic [ADDR_W-2:0] wrap_addr,
  output logic              fault
);
  logic [SEG_W-1:0] sel_seg;
  logic [SEG_W-1:0] code_seg;
  logic [OFS_W-1:0] ofs;

  seg_regfile #(.SEG_W(SEG_W)) regs_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_sel   (wr_sel),
    .wr_data  (wr_data),
    .far_ld   (far_ld),
    .far_cs   (far_cs),
    .ptr_ld   (ptr_ld),
    .ptr_data (ptr_data),
    .rd_sel   (seg_sel),
    .rd_seg   (sel_seg),
    .code_seg (code_seg)
  );

  seg_ea_check #(.EA_W(EA_W), .OFS_W(OFS_W)) chk_ea_i (
    .ea      (ea),
    .ea_wide (ea_wide),
    .ofs     (ofs),
    .fault   (fault)
  );

  seg_addr_calc #(.SEG_W(SEG_W), .OFS_W(OFS_W), .SHIFT(SHIFT)) calc_i (
    .seg       (sel_seg),
    .ofs       (ofs),
    .ext_mode  (ext_mode),
    .fault     (fault),
    .lin_addr  (lin_addr),
    .wrap_addr (wrap_addr)
  );
endmodule

// File: rtl/seg_addr_chk.sv
module seg_addr_chk #(
  parameter int unsigned SEG_W  = 16,
  parameter int unsigned ADDR_W = 21
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ext_mode,
  input logic              fault,
  input logic [ADDR_W-1:0] lin_addr,
  input logic [ADDR_W-2:0] wrap_addr,
  input logic              wr_en,
  input logic [1:0]        wr_sel,
  input logic              far_ld,
  input logic [SEG_W-1:0]  far_cs,
  input logic [SEG_W-1:0]  code_seg
);
  // R4
  fault_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (lin_addr == '0 && wrap_addr == '0));

  // R2
  compat_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_mode && !fault) |-> (lin_addr == {1'b0, wrap_addr}));

  // R3
  ext_low_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_mode && !fault) |-> (lin_addr[ADDR_W-2:0] == wrap_addr));

  // R6
  code_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 2'b01 && !far_ld) |=> $stable(code_seg));

  // R7
  far_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    far_ld |=> (code_seg == $past(far_cs)));
endmodule

bind seg_addr_gen seg_addr_chk #(.SEG_W(SEG_W), .ADDR_W(ADDR_W)) sva_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .ext_mode  (ext_mode),
  .fault     (fault),
  .lin_addr  (lin_addr),
  .wrap_addr (wrap_addr),
  .wr_en     (wr_en),
  .wr_sel    (wr_sel),
  .far_ld    (far_ld),
  .far_cs    (far_cs),
  .code_seg  (code_seg)
);

// File: tb/seg_addr_gen_tb.sv
`timescale 1ns/1ps
module seg_addr_gen_tb_top;
  logic        clk;
  logic        rst_n;
  logic [1:0]  seg_sel;
  logic [31:0] ea;
  logic        ea_wide;
  logic        ext_mode;
  logic        wr_en;
  logic [1:0]  wr_sel;
  logic [15:0] wr_data;
  logic        far_ld;
  logic [15:0] far_cs;
  logic        ptr_ld;
  logic [15:0] ptr_data;
  logic [20:0] lin_addr;
  logic [19:0] wrap_addr;
  logic        fault;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  seg_addr_gen dut_i (
    .clk(clk), .rst_n(rst_n), .seg_sel(seg_sel), .ea(ea), .ea_wide(ea_wide),
    .ext_mode(ext_mode), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .far_ld(far_ld), .far_cs(far_cs), .ptr_ld(ptr_ld), .ptr_data(ptr_data),
    .lin_addr(lin_addr), .wrap_addr(wrap_addr), .fault(fault)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // apply address inputs and check all three outputs
  task automatic probe(input string req, input logic [1:0] s, input logic [31:0] e,
                       input logic wide, input logic ext, input logic [15:0] segv);
    logic [31:0] sum;
    logic        flt;
    seg_sel = s; ea = e; ea_wide = wide; ext_mode = ext;
    #1;
    flt = wide && (e[31:16] != 16'h0);
    sum = ({16'h0, segv} << 4) + {16'h0, e[15:0]};
    if (flt) begin
      check(req, {31'h0, fault}, 32'd1);
      check(req, {11'h0, lin_addr}, 32'h0);
      check(req, {12'h0, wrap_addr}, 32'h0);
    end else begin
      check(req, {31'h0, fault}, 32'd0);
      check(req, {11'h0, lin_addr}, ext ? (sum & 32'h1FFFFF) : (sum & 32'hFFFFF));
      check(req, {12'h0, wrap_addr}, sum & 32'hFFFFF);
    end
  endtask

  task automatic cyc_write(input logic we, input logic [1:0] ws, input logic [15:0] wd,
                           input logic fl, input logic [15:0] fc,
                           input logic pl, input logic [15:0] pd);
    @(negedge clk);
    wr_en = we; wr_sel = ws; wr_data = wd;
    far_ld = fl; far_cs = fc; ptr_ld = pl; ptr_data = pd;
    @(negedge clk);
    wr_en = 1'b0; far_ld = 1'b0; ptr_ld = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; seg_sel = 2'b00; ea = '0; ea_wide = 1'b0; ext_mode = 1'b0;
    wr_en = 1'b0; wr_sel = 2'b00; wr_data = '0; far_ld = 1'b0; far_cs = '0;
    ptr_ld = 1'b0; ptr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R9 R5 reset values, read through zero offset
    probe("R9 extra",  2'b00, 32'h0, 1'b0, 1'b0, 16'h0000);
    probe("R9 code",   2'b01, 32'h0, 1'b0, 1'b0, 16'hFFFF);
    probe("R9 stack",  2'b10, 32'h0, 1'b0, 1'b0, 16'h0000);
    probe("R9 data",   2'b11, 32'h0, 1'b0, 1'b0, 16'h0000);

    // R6 R5 ordinary writes to extra, stack, data
    cyc_write(1'b1, 2'b00, 16'h1111, 1'b0, 16'h0, 1'b0, 16'h0);
    cyc_write(1'b1, 2'b10, 16'h2222, 1'b0, 16'h0, 1'b0, 16'h0);
    cyc_write(1'b1, 2'b11, 16'h3333, 1'b0, 16'h0, 1'b0, 16'h0);
    probe("R6 extra", 2'b00, 32'h5, 1'b0, 1'b0, 16'h1111);
    probe("R6 stack", 2'b10, 32'h5, 1'b0, 1'b0, 16'h2222);
    probe("R6 data",  2'b11, 32'h5, 1'b0, 1'b0, 16'h3333);

    // R6 ordinary write to code is ignored
    cyc_write(1'b1, 2'b01, 16'h1234, 1'b0, 16'h0, 1'b0, 16'h0);
    probe("R6 code ignored", 2'b01, 32'h0, 1'b0, 1'b1, 16'hFFFF);

    // R7 far load of code
    cyc_write(1'b0, 2'b00, 16'h0, 1'b1, 16'h4567, 1'b0, 16'h0);
    probe("R7 far load", 2'b01, 32'h9, 1'b0, 1'b0, 16'h4567);

    // R8 pointer load beats ordinary write to data
    cyc_write(1'b1, 2'b11, 16'hAAAA, 1'b0, 16'h0, 1'b1, 16'h5555);
    probe("R8 ptr wins", 2'b11, 32'h0, 1'b0, 1'b0, 16'h5555);
    // R8 pointer load alongside a write to stack
    cyc_write(1'b1, 2'b10, 16'h0777, 1'b0, 16'h0, 1'b1, 16'h0888);
    probe("R8 data",  2'b11, 32'h0, 1'b0, 1'b0, 16'h0888);
    probe("R8 stack", 2'b10, 32'h0, 1'b0, 1'b0, 16'h0777);

    // R4 range checks
    cyc_write(1'b1, 2'b00, 16'h1000, 1'b0, 16'h0, 1'b0, 16'h0);
    probe("R4 wide max ok",   2'b00, 32'h0000FFFF, 1'b1, 1'b1, 16'h1000);
    probe("R4 wide 65536",    2'b00, 32'h00010000, 1'b1, 1'b1, 16'h1000);
    probe("R4 wide top",      2'b00, 32'hFFFFFFFF, 1'b1, 1'b0, 16'h1000);
    probe("R4 narrow ignore", 2'b00, 32'hABCD0042, 1'b0, 1'b0, 16'h1000);

    // R2 R3 carry boundary
    cyc_write(1'b1, 2'b10, 16'hFFFF, 1'b0, 16'h0, 1'b0, 16'h0);
    probe("R2 wrap", 2'b10, 32'h0010, 1'b0, 1'b0, 16'hFFFF);
    probe("R3 keep", 2'b10, 32'h0010, 1'b0, 1'b1, 16'hFFFF);
    probe("R3 keep max", 2'b10, 32'hFFFF, 1'b0, 1'b1, 16'hFFFF);

    // R10 outputs follow inputs without a clock: change sel mid-cycle
    @(negedge clk);
    #1 probe("R10 sel stack", 2'b10, 32'h1, 1'b0, 1'b0, 16'hFFFF);
    #1 probe("R10 sel extra", 2'b00, 32'h1, 1'b0, 1'b0, 16'h1000);

    // R1 R2 R3 sweep over stack values, offsets and modes
    for (int s = 0; s <= 65535; s += 4369) begin
      cyc_write(1'b1, 2'b10, s[15:0], 1'b0, 16'h0, 1'b0, 16'h0);
      for (int o = 0; o <= 65535; o += 4369) begin
        for (int m = 0; m < 2; m++) begin
          probe("R1 sweep", 2'b10, o, 1'b0, m[0], s[15:0]);
        end
      end
    end

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule